// File: doc/BRIEF.md
# Virtualizable Privileged Timer Counter Block

This block keeps two free-running 64-bit counters for a processor core. The first counts the cycles in which a resource is in use. The second is an interval counter. It has a match register that raises a timer interrupt, and an offset register that a virtual machine monitor sets so that a guest sees a shifted time base. Software reaches all four registers through one request port. Each request carries a register select, a read/write bit, write data, the requester's privilege level, a flag that protects the utilization counter, and a flag that marks guest execution.

Each request gets one response on the following cycle. A response holds either read data or a privileged-register fault. The access rules depend on privilege level 0, which is the most privileged. The guest offset is added only to interval-counter reads made while the guest flag is set. The interrupt comparison always uses the raw counter. Two parameters can remove the utilization counter or the offset register. A removed register reads as zero and ignores writes.

Top module: `vtmr_top`

## Requirements
- R1: The utilization counter increases by one at every clock edge where `utilIncEn` is high. From all-ones it wraps to 0 with no indication.
- R2: The interval counter increases by one at every clock edge where `itcIncEn` is high. It wraps from all-ones to 0 in the same way.
- R3: When `secureFlag` is 0, a read of the utilization counter is accepted at every privilege level. It returns the counter value from the cycle in which the request is presented.
- R4: When `secureFlag` is 1, a read of the utilization counter at a privilege level other than 0 gives a fault response with zero read data.
- R5: A write to any present register is accepted only at privilege level 0. At any other level the write gives a fault response.
- R6: A faulting request changes no register. Its fault is a one-cycle pulse, coincident with `rspValid`, and it is followed by no fault when the next cycle carries no request.
- R7: An accepted write takes effect at the clock edge that samples the request. If the target counter's increment enable is high in the same cycle, the written value is kept and the increment is dropped.
- R8: When `vmFlag` is 1, a read of the interval counter returns the counter plus the offset register, modulo 2^64. When `vmFlag` is 0, the read returns the raw counter and the offset has no effect.
- R9: `matchIrq` is high in a cycle exactly when, at the previous edge, the raw interval counter equalled the match register. The offset plays no part. The match register resets to all-ones.
- R10: Successive accepted reads of the utilization counter return non-decreasing values in request order while the counter does not wrap.
- R11: With `UTIL_PRESENT` or `OFFSET_PRESENT` set to 0, the removed register reads as zero, never faults, and ignores writes. An absent offset leaves guest reads of the interval counter equal to the raw counter.
- R12: The select encoding is 0 for the utilization counter, 1 for the interval counter, 2 for the match register and 3 for the offset register. A response (`rspValid`, `rspFault`, `rspRdata`) appears in the cycle after the request. Write responses carry zero data. After reset, both counters and the offset read as zero and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Register request present this cycle |
| reqSel | input | 2 | Register select (0 util, 1 interval, 2 match, 3 offset) |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | W | Write data |
| reqPriv | input | 2 | Requester privilege level, 0 most privileged |
| secureFlag | input | 1 | Protects utilization counter reads from levels other than 0 |
| vmFlag | input | 1 | Guest execution: apply offset to interval counter reads |
| utilIncEn | input | 1 | Increment enable for the utilization counter |
| itcIncEn | input | 1 | Increment enable for the interval counter |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspFault | output | 1 | Privileged-register fault for that request |
| rspRdata | output | W | Read data, zero on fault or write |
| matchIrq | output | 1 | Timer match interrupt |

## Verification
The access checker is swept over every mix of select, direction, privilege level, secure flag and guest flag, with both counters held still. A fault, accepted data or a wrong offset then shows up as a single mismatch against the arithmetic model. A second instance with both optional registers removed receives the same sweep, which separates the removed-register behaviour from the privilege rules. Directed patterns run the counters while requests arrive. A long enable run checks the count, and single steps from all-ones check the wrap. A write in a cycle where the increment enable is high shows whether the write or the increment wins. Back-to-back reads during counting test the ordering. A match run with a large guest offset and the guest flag set shows whether the interrupt fires on the raw count or on the offset count.

// File: rtl/vtmr_pkg.sv
package vtmr_pkg;

  typedef enum logic [1:0] {
    SEL_UTIL   = 2'd0,
    SEL_ITC    = 2'd1,
    SEL_MATCH  = 2'd2,
    SEL_OFFSET = 2'd3
  } regSel_e;

  // Strobes from the access checker to the datapath
  typedef struct packed {
    logic    ack;       // a request is answered next cycle
    logic    fault;     // request refused
    logic    rdGo;      // accepted read
    regSel_e rdSel;     // register to read
    logic    wrUtil;
    logic    wrItc;
    logic    wrMatch;
    logic    wrOffset;
  } ctrlStrobes_t;

endpackage

// File: rtl/vtmr_counter.sv
module vtmr_counter #(
  parameter int W       = 64,
  parameter bit PRESENT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         incEn,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count
);

  generate
    if (PRESENT) begin : g_cnt
      logic [W-1:0] cntQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      cntQ <= '0;
        else if (load)  cntQ <= loadVal;       // write beats increment
        else if (incEn) cntQ <= cntQ + 1'b1;   // silent wrap
      end
      assign count = cntQ;
    end else begin : g_absent
      assign count = '0;
    end
  endgenerate

endmodule

// File: rtl/vtmr_ctrl.sv
module vtmr_ctrl
  import vtmr_pkg::*;
#(
  parameter bit UTIL_PRESENT   = 1'b1,
  parameter bit OFFSET_PRESENT = 1'b1
) (
  input  logic         reqValid,
  input  logic [1:0]   reqSel,
  input  logic         reqWrite,
  input  logic [1:0]   reqPriv,
  input  logic         secureFlag,
  output ctrlStrobes_t strobes
);

  regSel_e sel;
  logic    privZero;
  logic    selPresent;
  logic    denyRead;
  logic    denyWrite;
  logic    refuse;
  logic    accepted;

  assign sel      = regSel_e'(reqSel);
  assign privZero = (reqPriv == 2'd0);

  always_comb begin
    unique case (sel)
      SEL_UTIL:   selPresent = UTIL_PRESENT;
      SEL_OFFSET: selPresent = OFFSET_PRESENT;
      default:    selPresent = 1'b1;
    endcase
  end

  assign denyWrite = !privZero;
  assign denyRead  = (sel == SEL_UTIL) && secureFlag && !privZero;
  assign refuse    = reqValid && selPresent && (reqWrite ? denyWrite : denyRead);
  assign accepted  = reqValid && !refuse;

  always_comb begin
    strobes          = '0;
    strobes.ack      = reqValid;
    strobes.fault    = refuse;
    strobes.rdGo     = accepted && !reqWrite;
    strobes.rdSel    = sel;
    strobes.wrUtil   = accepted && reqWrite && selPresent && (sel == SEL_UTIL);
    strobes.wrItc    = accepted && reqWrite && (sel == SEL_ITC);
    strobes.wrMatch  = accepted && reqWrite && (sel == SEL_MATCH);
    strobes.wrOffset = accepted && reqWrite && selPresent && (sel == SEL_OFFSET);
  end

endmodule

// File: rtl/vtmr_dp.sv
module vtmr_dp
  import vtmr_pkg::*;
#(
  parameter int W              = 64,
  parameter bit UTIL_PRESENT   = 1'b1,
  parameter bit OFFSET_PRESENT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] reqWdata,
  input  logic         vmFlag,
  input  logic         utilIncEn,
  input  logic         itcIncEn,
  output logic         rspValid,
  output logic         rspFault,
  output logic [W-1:0] rspRdata,
  output logic         matchIrq,
  output logic [W-1:0] utilCnt,
  output logic [W-1:0] itcCnt,
  output logic [W-1:0] matchReg
);

  logic [W-1:0] offsetReg;
  logic [W-1:0] guestItc;
  logic [W-1:0] rdMux;

  vtmr_counter #(.W(W), .PRESENT(UTIL_PRESENT)) u_utilCnt (
    .clk(clk), .rstN(rstN), .incEn(utilIncEn),
    .load(strobes.wrUtil), .loadVal(reqWdata), .count(utilCnt)
  );

  vtmr_counter #(.W(W), .PRESENT(1'b1)) u_itcCnt (
    .clk(clk), .rstN(rstN), .incEn(itcIncEn),
    .load(strobes.wrItc), .loadVal(reqWdata), .count(itcCnt)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                matchReg <= '1;
    else if (strobes.wrMatch) matchReg <= reqWdata;
  end

  generate
    if (OFFSET_PRESENT) begin : g_off
      logic [W-1:0] offQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 offQ <= '0;
        else if (strobes.wrOffset) offQ <= reqWdata;
      end
      assign offsetReg = offQ;
    end else begin : g_no_off
      assign offsetReg = '0;
    end
  endgenerate

  // Guest view: offset only on the read path
  assign guestItc = itcCnt + offsetReg;

  always_comb begin
    unique case (strobes.rdSel)
      SEL_UTIL:   rdMux = utilCnt;
      SEL_ITC:    rdMux = vmFlag ? guestItc : itcCnt;
      SEL_MATCH:  rdMux = matchReg;
      default:    rdMux = offsetReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspRdata <= '0;
      matchIrq <= 1'b0;
    end else begin
      rspValid <= strobes.ack;
      rspFault <= strobes.fault;
      rspRdata <= strobes.rdGo ? rdMux : '0;
      matchIrq <= (itcCnt == matchReg);   // raw count, never the offset
    end
  end

endmodule

// File: rtl/vtmr_top.sv
module vtmr_top
  import vtmr_pkg::*;
#(
  parameter int W              = 64,
  parameter bit UTIL_PRESENT   = 1'b1,
  parameter bit OFFSET_PRESENT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   reqSel,
  input  logic         reqWrite,
  input  logic [W-1:0] reqWdata,
  input  logic [1:0]   reqPriv,
  input  logic         secureFlag,
  input  logic         vmFlag,
  input  logic         utilIncEn,
  input  logic         itcIncEn,
  output logic         rspValid,
  output logic         rspFault,
  output logic [W-1:0] rspRdata,
  output logic         matchIrq
);

  ctrlStrobes_t strobes;
  logic [W-1:0] utilCnt;
  logic [W-1:0] itcCnt;
  logic [W-1:0] matchReg;

  vtmr_ctrl #(.UTIL_PRESENT(UTIL_PRESENT), .OFFSET_PRESENT(OFFSET_PRESENT)) u_ctrl (
    .reqValid(reqValid), .reqSel(reqSel), .reqWrite(reqWrite),
    .reqPriv(reqPriv), .secureFlag(secureFlag), .strobes(strobes)
  );

  vtmr_dp #(.W(W), .UTIL_PRESENT(UTIL_PRESENT), .OFFSET_PRESENT(OFFSET_PRESENT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqWdata(reqWdata),
    .vmFlag(vmFlag), .utilIncEn(utilIncEn), .itcIncEn(itcIncEn),
    .rspValid(rspValid), .rspFault(rspFault), .rspRdata(rspRdata),
    .matchIrq(matchIrq), .utilCnt(utilCnt), .itcCnt(itcCnt), .matchReg(matchReg)
  );

endmodule

// File: rtl/vtmr_checker.sv
module vtmr_checker #(
  parameter int W            = 64,
  parameter bit UTIL_PRESENT = 1'b1
) (
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic [1:0]   reqSel,
  input logic         reqWrite,
  input logic [1:0]   reqPriv,
  input logic         secureFlag,
  input logic         vmFlag,
  input logic         utilIncEn,
  input logic         rspValid,
  input logic         rspFault,
  input logic [W-1:0] rspRdata,
  input logic         matchIrq,
  input logic [W-1:0] utilCnt,
  input logic [W-1:0] itcCnt,
  input logic [W-1:0] matchReg
);

  logic utilReq;
  logic utilWrOk;
  assign utilReq  = reqValid && (reqSel == 2'd0);
  assign utilWrOk = utilReq && reqWrite && (reqPriv == 2'd0);

  // R1: count step when no write lands
  a_r1_util_step: assert property (@(posedge clk) disable iff (!rstN)
    (UTIL_PRESENT && utilIncEn && !utilWrOk) |=> utilCnt == W'($past(utilCnt) + 1'b1));

  // R3: unsecured reads never fault
  a_r3_open_read: assert property (@(posedge clk) disable iff (!rstN)
    (utilReq && !reqWrite && !secureFlag) |=> !rspFault);

  // R4: secured read from a lesser level faults
  a_r4_secure_read: assert property (@(posedge clk) disable iff (!rstN)
    (UTIL_PRESENT && utilReq && !reqWrite && secureFlag && reqPriv != 2'd0) |=> rspFault);

  // R5: write from a lesser level faults
  a_r5_write_priv: assert property (@(posedge clk) disable iff (!rstN)
    (UTIL_PRESENT && utilReq && reqWrite && reqPriv != 2'd0) |=> rspFault);

  // R6: fault comes with a response and no data
  a_r6_fault_shape: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspValid && rspRdata == '0));

  // R8: host read of interval counter is raw
  a_r8_host_raw: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSel == 2'd1 && !vmFlag) |=> rspRdata == $past(itcCnt));

  // R9: interrupt follows raw equality
  a_r9_irq_hit: assert property (@(posedge clk) disable iff (!rstN)
    (itcCnt == matchReg) |=> matchIrq);
  a_r9_irq_miss: assert property (@(posedge clk) disable iff (!rstN)
    (itcCnt != matchReg) |=> !matchIrq);

  // R12: one response per request, next cycle
  a_r12_rsp_timing: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspFault));

endmodule

bind vtmr_top vtmr_checker #(.W(W), .UTIL_PRESENT(UTIL_PRESENT)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel),
  .reqWrite(reqWrite), .reqPriv(reqPriv), .secureFlag(secureFlag),
  .vmFlag(vmFlag), .utilIncEn(utilIncEn), .rspValid(rspValid),
  .rspFault(rspFault), .rspRdata(rspRdata), .matchIrq(matchIrq),
  .utilCnt(utilCnt), .itcCnt(itcCnt), .matchReg(matchReg)
);

// File: tb/vtmr_top_bench.sv
`timescale 1ns/1ps
module vtmr_top_bench;

  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [1:0]   reqSel = 2'd0;
  logic         reqWrite = 1'b0;
  logic [W-1:0] reqWdata = '0;
  logic [1:0]   reqPriv = 2'd0;
  logic         secureFlag = 1'b0;
  logic         vmFlag = 1'b0;
  logic         utilIncEn = 1'b0;
  logic         itcIncEn = 1'b0;

  logic         rspValid, rspFault, matchIrq;
  logic [W-1:0] rspRdata;
  logic         rspValidL, rspFaultL, matchIrqL;
  logic [W-1:0] rspRdataL;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [W-1:0] mUtil, mItc, mMatch, mOff;
  logic         lastF, lastFL;
  logic [W-1:0] lastRd, lastRdL;

  always #2 clk = ~clk;

  vtmr_top #(.W(W)) u_vtmr_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqPriv(reqPriv),
    .secureFlag(secureFlag), .vmFlag(vmFlag), .utilIncEn(utilIncEn),
    .itcIncEn(itcIncEn), .rspValid(rspValid), .rspFault(rspFault),
    .rspRdata(rspRdata), .matchIrq(matchIrq)
  );

  vtmr_top #(.W(W), .UTIL_PRESENT(1'b0), .OFFSET_PRESENT(1'b0)) u_lite (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqPriv(reqPriv),
    .secureFlag(secureFlag), .vmFlag(vmFlag), .utilIncEn(utilIncEn),
    .itcIncEn(itcIncEn), .rspValid(rspValidL), .rspFault(rspFaultL),
    .rspRdata(rspRdataL), .matchIrq(matchIrqL)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic access(input logic [1:0] sel, input logic wr, input logic [W-1:0] data,
                        input logic [1:0] priv, input logic sec, input logic vm);
    reqValid = 1'b1; reqSel = sel; reqWrite = wr; reqWdata = data;
    reqPriv = priv; secureFlag = sec; vmFlag = vm;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    check(rspValid == 1'b1, "R12 rspValid", W'(rspValid), 1);
    lastF = rspFault; lastRd = rspRdata;
    lastFL = rspFaultL; lastRdL = rspRdataL;
  endtask

  task automatic wr0(input logic [1:0] sel, input logic [W-1:0] data);
    access(sel, 1'b1, data, 2'd0, 1'b0, 1'b0);
    case (sel)
      2'd0: mUtil = data;
      2'd1: mItc = data;
      2'd2: mMatch = data;
      default: mOff = data;
    endcase
  endtask

  function automatic logic [W-1:0] modelRead(input logic [1:0] sel, input logic vm);
    case (sel)
      2'd0: return mUtil;
      2'd1: return vm ? mItc + mOff : mItc;
      2'd2: return mMatch;
      default: return mOff;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev;
    logic expF, expFL;
    logic [W-1:0] expRd, expRdL;
    int n;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12: reset state
    check(rspValid == 1'b0 && rspFault == 1'b0, "R12 reset rsp", W'({rspValid, rspFault}), 0);
    mUtil = '0; mItc = '0; mMatch = '1; mOff = '0;
    for (int s = 0; s < 4; s++) begin
      access(2'(s), 1'b0, '0, 2'd0, 1'b0, 1'b0);
      check(lastRd == modelRead(2'(s), 1'b0), "R12 reset read", lastRd, modelRead(2'(s), 1'b0));
    end
    check(matchIrq == 1'b0, "R9 reset irq", W'(matchIrq), 0);

    // Known contents
    wr0(2'd0, 64'h1111_2222_3333_4444);
    wr0(2'd1, 64'hFFFF_FFFF_FFFF_FF00);
    wr0(2'd2, 64'h0000_0000_0000_0777);
    wr0(2'd3, 64'h0000_0000_0000_0200);

    // R3 R4 R5 R8 R11: full access sweep, counters frozen
    n = 0;
    for (int p = 0; p < 4; p++)
      for (int sc = 0; sc < 2; sc++)
        for (int v = 0; v < 2; v++)
          for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
              logic [W-1:0] d;
              d = {32'hA5C3_0000, 32'(n)} + (W'(s) << 40);
              n++;
              expF = (w == 1) ? (p != 0) : (s == 0 && sc == 1 && p != 0);
              expFL = expF && (s == 1 || s == 2);
              expRd = (expF || w == 1) ? '0 : modelRead(2'(s), 1'(v));
              // lite view: no util, offset reads zero and adds nothing
              if (expFL || w == 1 || s == 0 || s == 3) expRdL = '0;
              else if (s == 1) expRdL = mItc;
              else expRdL = mMatch;
              access(2'(s), 1'(w), d, 2'(p), 1'(sc), 1'(v));
              check(lastF == expF, "R4 R5 sweep fault", W'(lastF), W'(expF));
              check(lastRd == expRd, "R3 R8 sweep data", lastRd, expRd);
              check(lastFL == expFL && lastRdL == expRdL, "R11 sweep lite", lastRdL, expRdL);
              if (w == 1 && !expF) begin
                case (s)
                  0: mUtil = d;
                  1: mItc = d;
                  2: mMatch = d;
                  default: mOff = d;
                endcase
              end
            end

    // R6: faulting write leaves counter alone, fault lasts one cycle
    wr0(2'd0, 64'h0000_0000_0000_0055);
    access(2'd0, 1'b1, 64'hDEAD, 2'd2, 1'b0, 1'b0);
    check(lastF == 1'b1 && lastRd == '0, "R6 fault data", lastRd, 0);
    @(posedge clk); @(negedge clk);
    check(rspFault == 1'b0 && rspValid == 1'b0, "R6 fault pulse", W'(rspFault), 0);
    access(2'd0, 1'b0, '0, 2'd0, 1'b0, 1'b0);
    check(lastRd == 64'h55, "R6 unchanged", lastRd, 64'h55);

    // R1: ten counting cycles
    wr0(2'd0, 64'd5);
    utilIncEn = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    utilIncEn = 1'b0;
    access(2'd0, 1'b0, '0, 2'd3, 1'b0, 1'b0);
    check(lastRd == 64'd15, "R1 count", lastRd, 64'd15);
    check(lastRdL == '0, "R11 lite util zero", lastRdL, 0);

    // R1: silent wrap
    wr0(2'd0, '1);
    utilIncEn = 1'b1;
    @(posedge clk); @(negedge clk);
    utilIncEn = 1'b0;
    access(2'd0, 1'b0, '0, 2'd0, 1'b0, 1'b0);
    check(lastRd == '0, "R1 wrap", lastRd, 0);

    // R2: interval wrap
    wr0(2'd1, 64'hFFFF_FFFF_FFFF_FFFE);
    itcIncEn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    itcIncEn = 1'b0;
    access(2'd1, 1'b0, '0, 2'd1, 1'b0, 1'b0);
    check(lastRd == 64'd1, "R2 wrap", lastRd, 64'd1);

    // R7: write wins over increment in the same cycle
    utilIncEn = 1'b1;
    wr0(2'd0, 64'd100);
    utilIncEn = 1'b0;
    access(2'd0, 1'b0, '0, 2'd0, 1'b0, 1'b0);
    check(lastRd == 64'd100, "R7 write wins", lastRd, 64'd100);

    // R10: back-to-back reads while counting
    utilIncEn = 1'b1;
    access(2'd0, 1'b0, '0, 2'd1, 1'b0, 1'b0);
    prev = lastRd;
    for (int k = 0; k < 6; k++) begin
      access(2'd0, 1'b0, '0, 2'd1, 1'b0, 1'b0);
      check(lastRd >= prev && lastRd == prev + 1, "R10 ordering", lastRd, prev + 1);
      prev = lastRd;
    end
    utilIncEn = 1'b0;

    // R9: match on raw count with a large guest offset
    wr0(2'd3, 64'd1000);
    wr0(2'd1, 64'd20);
    wr0(2'd2, 64'd23);
    @(posedge clk); @(negedge clk);
    check(matchIrq == 1'b0, "R9 idle no irq", W'(matchIrq), 0);
    vmFlag = 1'b1;
    itcIncEn = 1'b1;
    for (int j = 1; j <= 8; j++) begin
      @(posedge clk); @(negedge clk);
      check(matchIrq == ((19 + j) == 23), "R9 irq timing", W'(matchIrq), W'((19 + j) == 23));
    end
    itcIncEn = 1'b0;
    mItc = 64'd28;

    // R8: guest and host view after counting
    access(2'd1, 1'b0, '0, 2'd3, 1'b0, 1'b1);
    check(lastRd == 64'd1028, "R8 guest read", lastRd, 64'd1028);
    check(lastRdL == 64'd28, "R11 lite guest raw", lastRdL, 64'd28);
    access(2'd1, 1'b0, '0, 2'd3, 1'b0, 1'b0);
    check(lastRd == 64'd28, "R8 host read", lastRd, 64'd28);

    // R8: offset sum wraps modulo 2^64
    wr0(2'd3, '1);
    access(2'd1, 1'b0, '0, 2'd0, 1'b0, 1'b1);
    check(lastRd == 64'd27, "R8 guest wrap", lastRd, 64'd27);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule